// File: doc/BRIEF.md
# Synchronous BCD Decade Counter

A four-bit counter that steps through the decimal digits 0 to 9 and then returns to 0. Every register bit updates on the same rising clock edge, so all outputs change together and never pass through intermediate values. Two control inputs, clear and load, are both active low and synchronous. When asserted they take effect at the next rising edge, whatever the enable levels are. The load input copies a four-bit data word into the counter.

Counting needs two enables: a parallel enable and a trickle enable. The carry output is a combinational decode of "trickle enable high and digit at its last value". Feeding one stage's carry into the next stage's trickle enable chains digits into a synchronous multi-digit counter. Decoding a chosen count and returning it to the clear input gives a shorter cycle that still includes the decoded value.

Top module: `bcd_decade_counter`

## Requirements
- R1: While clr_n is low at a rising edge, count becomes 0 after that edge, whatever load_n, ena_par and ena_trk are. Clear takes precedence over load.
- R2: While clr_n is high and load_n is low at a rising edge, count takes the value of din after that edge, whatever the enables are.
- R3: With clr_n and load_n high and both enables high, count advances by one per rising edge from 0 up to 8. From 9 it returns to 0.
- R4: With clr_n and load_n high and either enable low, count keeps its value across the edge.
- R5: carry_out is high exactly when ena_trk is high and count equals 9. It follows ena_trk within the same cycle and does not depend on ena_par.
- R6: A count from 10 to 14 loaded by the user advances by one when enabled. From 15 it advances to 0, so the counter is back in range after at most six enabled edges.
- R7: carry_out is never high while count holds a value from 10 to 15.
- R8: Driving clr_n low whenever count equals a chosen value N gives a repeating cycle 0..N that includes N.
- R9: Two stages can be chained, with the upper stage's ena_trk driven by the lower stage's carry_out and both stages clocked together. They then count 00 to 99 in decimal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| ena_par | input | 1 | Parallel count enable |
| ena_trk | input | 1 | Trickle count enable; also gates carry_out |
| din | input | 4 | Value loaded while load_n is low |
| count | output | 4 | Current BCD digit |
| carry_out | output | 1 | Look-ahead carry for the next stage |

## Verification
The hardest states to reach are the six invalid codes 10 to 15. Counting from a clear never produces them, so the bench reaches them only through a parallel load. It loads 13, then steps the counter while checking that it moves 14, 15, 0 and that carry_out stays low throughout, even with ena_trk high. The cascade case needs a lower stage's carry to line up with an upper stage's enable at the same edge. A second instance, driven by the first one's carry, is run through 25 edges, and the bench compares the decimal sum against the edge count.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
    localparam int DIGIT_W = 4;
    localparam int DIGIT_LAST = 9;

    // Operation selected for the next rising edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;
endpackage

// File: rtl/bcd_ctr_mode.sv
module bcd_ctr_mode
    import bcd_ctr_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    ena_par,
    input  logic    ena_trk,
    output ctr_op_e op
);
    always_comb begin
        if (!clr_n)                  op = OP_CLEAR;
        else if (!load_n)            op = OP_LOAD;
        else if (ena_par && ena_trk) op = OP_COUNT;
        else                         op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_ctr_step.sv
module bcd_ctr_step #(
    parameter int WIDTH = 4,
    parameter int LAST  = 9
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);
    localparam logic [WIDTH-1:0] ONE_V  = WIDTH'(1);

    // Codes above LAST roll over through the natural binary wrap.
    always_comb begin
        if (cur == LAST_V) nxt = '0;
        else               nxt = cur + ONE_V;
    end
endmodule

// File: rtl/bcd_ctr_carry.sv
module bcd_ctr_carry #(
    parameter int WIDTH = 4,
    parameter int LAST  = 9
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             ena_trk,
    output logic             carry
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    always_comb carry = ena_trk && (cur == LAST_V);
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_ctr_pkg::*;
#(
    parameter int WIDTH = DIGIT_W,
    parameter int LAST  = DIGIT_LAST
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             ena_par,
    input  logic             ena_trk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } ctr_state_t;

    ctr_state_t state_d, state_q;
    ctr_op_e    op;
    logic [WIDTH-1:0] inc_value;

    bcd_ctr_mode u_mode (
        .clr_n   (clr_n),
        .load_n  (load_n),
        .ena_par (ena_par),
        .ena_trk (ena_trk),
        .op      (op)
    );

    bcd_ctr_step #(.WIDTH(WIDTH), .LAST(LAST)) u_step (
        .cur (state_q.value),
        .nxt (inc_value)
    );

    bcd_ctr_carry #(.WIDTH(WIDTH), .LAST(LAST)) u_carry (
        .cur     (state_q.value),
        .ena_trk (ena_trk),
        .carry   (carry_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CLEAR: state_d.value = '0;
            OP_LOAD:  state_d.value = din;
            OP_COUNT: state_d.value = inc_value;
            default:  state_d.value = state_q.value;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.value;

    // Checks become live once a clear has been sampled, since there is no reset.
    logic chk_live_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) chk_live_q <= 1'b1;
    end

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!chk_live_q)
        !clr_n |=> (count == '0));

    a_r2_load_copy: assert property (@(posedge clk) disable iff (!chk_live_q)
        (clr_n && !load_n) |=> (count == $past(din)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!chk_live_q)
        (clr_n && load_n && !(ena_par && ena_trk)) |=> $stable(count));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!chk_live_q)
        (clr_n && load_n && ena_par && ena_trk && count == LAST_V) |=> (count == '0));

    a_r7_no_carry_invalid: assert property (@(posedge clk) disable iff (!chk_live_q)
        (count > LAST_V) |-> !carry_out);

    a_r5_carry_needs_trk: assert property (@(posedge clk) disable iff (!chk_live_q)
        carry_out |-> (ena_trk && count == LAST_V));
endmodule

// File: tb/bcd_decade_counter_test.sv
`timescale 1ns/1ps
module bcd_decade_counter_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic       ena_par = 1'b0;
    logic       ena_trk = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] count;
    logic       carry_out;
    logic [3:0] count_hi;
    logic       carry_hi;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    bcd_decade_counter uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .ena_par(ena_par),
        .ena_trk(ena_trk), .din(din), .count(count), .carry_out(carry_out)
    );

    bcd_decade_counter uut_hi (
        .clk(clk), .clr_n(clr_n), .load_n(1'b1), .ena_par(1'b1),
        .ena_trk(carry_out), .din(4'd0), .count(count_hi), .carry_out(carry_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one edge; sample 2 ns after it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_clear();
        clr_n = 1'b0; tick(); clr_n = 1'b1;
    endtask

    task automatic t_reset_state();
        ena_par = 1'b1; ena_trk = 1'b1; load_n = 1'b0; din = 4'd7;
        clr_n = 1'b0; tick();
        chk("R1 clear beats load and enables", count, 0);
        clr_n = 1'b1; load_n = 1'b1; ena_par = 1'b0; ena_trk = 1'b0;
    endtask

    task automatic t_load();
        ena_par = 1'b0; ena_trk = 1'b0; din = 4'd6; load_n = 1'b0; tick();
        chk("R2 load with enables low", count, 6);
        ena_par = 1'b1; ena_trk = 1'b1; din = 4'd3; tick();
        chk("R2 load with enables high", count, 3);
        load_n = 1'b1;
    endtask

    task automatic t_count_wrap();
        do_clear();
        ena_par = 1'b1; ena_trk = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            tick();
            chk("R3 decade sequence", count, i % 10);
        end
        ena_par = 1'b0; ena_trk = 1'b0;
    endtask

    task automatic t_hold();
        din = 4'd4; load_n = 1'b0; tick(); load_n = 1'b1;
        ena_par = 1'b1; ena_trk = 1'b0; tick();
        chk("R4 hold trickle low", count, 4);
        ena_par = 1'b0; ena_trk = 1'b1; tick();
        chk("R4 hold parallel low", count, 4);
        ena_par = 1'b0; ena_trk = 1'b0; tick();
        chk("R4 hold both low", count, 4);
    endtask

    task automatic t_carry();
        din = 4'd9; load_n = 1'b0; tick(); load_n = 1'b1;
        ena_par = 1'b0; ena_trk = 1'b1; #1;
        chk("R5 carry at 9 trickle high, parallel low", carry_out, 1);
        ena_trk = 1'b0; #1;
        chk("R5 carry drops with trickle", carry_out, 0);
        ena_par = 1'b1; ena_trk = 1'b1; #1;
        chk("R5 carry at 9 both high", carry_out, 1);
        tick();
        chk("R5 carry low at 0", carry_out, 0);
        ena_par = 1'b0; ena_trk = 1'b0;
    endtask

    task automatic t_invalid();
        din = 4'd13; load_n = 1'b0; tick(); load_n = 1'b1;
        ena_trk = 1'b1; ena_par = 1'b0; #1;
        chk("R7 no carry at 13", carry_out, 0);
        ena_par = 1'b1;
        tick(); chk("R6 13 to 14", count, 14); chk("R7 no carry at 14", carry_out, 0);
        tick(); chk("R6 14 to 15", count, 15); chk("R7 no carry at 15", carry_out, 0);
        tick(); chk("R6 15 to 0", count, 0);
        tick(); chk("R6 back in range", count, 1);
        ena_par = 1'b0; ena_trk = 1'b0;
    endtask

    task automatic t_short();
        do_clear();
        ena_par = 1'b1; ena_trk = 1'b1;
        for (int i = 1; i <= 14; i++) begin
            clr_n = (count != 4'd5);
            tick();
            chk("R8 shortened cycle 0..5", count, i % 6);
        end
        clr_n = 1'b1; ena_par = 1'b0; ena_trk = 1'b0;
    endtask

    task automatic t_cascade();
        do_clear();
        chk("R9 upper stage cleared", count_hi, 0);
        ena_par = 1'b1; ena_trk = 1'b1;
        for (int i = 1; i <= 25; i++) begin
            tick();
            chk("R9 two-digit value", 10 * count_hi + count, i % 100);
        end
        ena_par = 1'b0; ena_trk = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3;
        t_reset_state();
        t_load();
        t_count_wrap();
        t_hold();
        t_carry();
        t_invalid();
        t_short();
        t_cascade();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule